// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Enable Unit

This block holds the eight interrupt flags and the eight matching enable bits of a stand-alone CAN controller. It drives the active-low interrupt line to the host. The protocol core supplies single-cycle strobes: bus error, arbitration lost, error-passive crossing, wake-up bus activity and sleep request. It also supplies level status signals: data overrun, error status, bus status, transmit buffer free and receive FIFO non-empty. From these the unit derives edge events, change events and a level-following receive flag.

The host reaches the unit through a plain register port. The flag register at address 3 is read-only. Reading it returns the flags and clears all of them except the receive flag. The enable register at address 4 is read/write. A release-receive-buffer pulse briefly masks the receive flag while the FIFO steps to its next entry. All control pins are plain levels and strobes, with no handshake, because no data stream passes through this unit.

Top module: `can_irq_unit`

## Requirements
- R1: The flag register is at address 3 with the bit order 7 bus error, 6 arbitration lost, 5 error passive, 4 wake-up, 3 data overrun, 2 error warning, 1 transmit, 0 receive. A write to address 3 has no effect.
- R2: The enable register at address 4 reads back what was written, using the same bit order. A flag can become set only while its enable bit is 1. Reads of any other address return 0.
- R3: A read of address 3 returns the current flags in that cycle. From the next cycle, bits 7 to 1 are cleared.
- R4: The receive flag (bit 0) equals receive-FIFO-not-empty AND receive enable. A flag register read does not clear it.
- R5: In the cycle after a release-receive-buffer pulse, the receive flag is 0. After that, it follows R4 again.
- R6: The data overrun flag sets on a 0-to-1 change of the data overrun status input. The transmit flag sets on a 0-to-1 change of the transmit buffer status input. A steady or falling input does not set either flag.
- R7: The error warning flag sets on any change, rising or falling, of the error status input or the bus status input.
- R8: The bus error, arbitration lost and error-passive-crossing strobes set flag bits 7, 6 and 5.
- R9: The wake-up flag sets on a wake strobe. It also sets on a sleep request while the bus is active or while any flag is set. A sleep request with an idle bus and no flag set leaves it clear.
- R10: The interrupt output is low exactly while any flag is set. If the receive flag is the only flag set, clearing the receive enable drives the output high in the cycle after the write.
- R11: If a set event and a clearing flag read fall in the same cycle, the flag ends up set.
- R12: A synchronous reset clears all flags and enables, and the interrupt output goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_err_evt | input | 1 | Strobe: bus error detected |
| arb_lost_evt | input | 1 | Strobe: arbitration lost |
| ep_cross_evt | input | 1 | Strobe: error-passive state entered or left |
| wake_bus_evt | input | 1 | Strobe: bus activity seen while asleep |
| sleep_req_evt | input | 1 | Strobe: host requests sleep |
| bus_active | input | 1 | Level: bus currently busy |
| dovr_sts | input | 1 | Level: data overrun status |
| err_sts | input | 1 | Level: error status |
| bus_sts | input | 1 | Level: bus-off status |
| txbuf_sts | input | 1 | Level: transmit buffer free |
| rxfifo_nonempty | input | 1 | Level: receive FIFO holds a message |
| rx_release | input | 1 | Strobe: release receive buffer command |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A stuck or stale edge-history bit shows up as a spurious or missing data-overrun, transmit or error-warning flag on the next flag read, one cycle after the input change. A clear that misfires on the receive bit shows up at once as a lost receive flag on the next read, while the FIFO is still non-empty. A wrong enable gate makes the interrupt line fall for a disabled source in the cycle after the strobe. The directed scenarios read the flag register immediately after each stimulus, so every such fault appears within two cycles.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NFLAG     = 8;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 5'd3;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 5'd4;
  // bit positions within flag and enable registers
  localparam int B_BUSERR = 7;
  localparam int B_ARB    = 6;
  localparam int B_EPASS  = 5;
  localparam int B_WAKE   = 4;
  localparam int B_DOVR   = 3;
  localparam int B_EWARN  = 2;
  localparam int B_TX     = 1;
  localparam int B_RX     = 0;
endpackage

// File: rtl/can_irq_edge.sv
// Per-bit change detector: rising edge, or any change where ANY_CHG bit is 1.
module can_irq_edge #(
  parameter int W = 4,
  parameter logic [W-1:0] ANY_CHG = '0
) (
  input  logic         clk,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);
  logic [W-1:0] hist_q;

  // history follows the input even in reset, so no false edge afterwards
  always_ff @(posedge clk) hist_q <= lvl;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ANY_CHG[i]) begin : g_any
      assign evt[i] = lvl[i] ^ hist_q[i];
    end else begin : g_rise
      assign evt[i] = lvl[i] & ~hist_q[i];
    end
  end
endmodule

// File: rtl/can_irq_flags.sv
// Flag bank: sticky flags cleared by read, one level-following bit.
module can_irq_flags #(
  parameter int W      = 8,
  parameter int LVL_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_evt,   // for LVL_BIT this is the level itself
  input  logic [W-1:0] en,
  input  logic         rd_clr,
  input  logic         rx_release,
  output logic [W-1:0] flags
);
  logic rel_q;

  always_ff @(posedge clk) begin
    if (rst) rel_q <= 1'b0;
    else     rel_q <= rx_release;
  end

  for (genvar i = 0; i < W; i++) begin : g_flag
    if (i == LVL_BIT) begin : g_level
      assign flags[i] = set_evt[i] & en[i] & ~rel_q;
    end else begin : g_sticky
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst)                      f_q <= 1'b0;
        else if (set_evt[i] && en[i]) f_q <= 1'b1;   // event beats clear
        else if (rd_clr)              f_q <= 1'b0;
      end
      assign flags[i] = f_q;
    end
  end
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_err_evt,
  input  logic              arb_lost_evt,
  input  logic              ep_cross_evt,
  input  logic              wake_bus_evt,
  input  logic              sleep_req_evt,
  input  logic              bus_active,
  input  logic              dovr_sts,
  input  logic              err_sts,
  input  logic              bus_sts,
  input  logic              txbuf_sts,
  input  logic              rxfifo_nonempty,
  input  logic              rx_release,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  localparam int NLVL = 4;
  // level order into the change detector
  localparam int L_DOVR = 0;
  localparam int L_TX   = 1;
  localparam int L_ERR  = 2;
  localparam int L_BUS  = 3;
  localparam logic [NLVL-1:0] ANY_MASK = (NLVL'(1) << L_ERR) | (NLVL'(1) << L_BUS);

  logic [NFLAG-1:0] en_q;
  logic [NFLAG-1:0] flag_vec;
  logic [NFLAG-1:0] set_vec;
  logic [NLVL-1:0]  lvl_vec;
  logic [NLVL-1:0]  chg_vec;
  logic             rd_clr;
  logic             pending;

  assign lvl_vec[L_DOVR] = dovr_sts;
  assign lvl_vec[L_TX]   = txbuf_sts;
  assign lvl_vec[L_ERR]  = err_sts;
  assign lvl_vec[L_BUS]  = bus_sts;

  can_irq_edge #(.W(NLVL), .ANY_CHG(ANY_MASK)) u_edge (
    .clk (clk),
    .lvl (lvl_vec),
    .evt (chg_vec)
  );

  assign pending = |flag_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[B_BUSERR] = bus_err_evt;
    set_vec[B_ARB]    = arb_lost_evt;
    set_vec[B_EPASS]  = ep_cross_evt;
    set_vec[B_WAKE]   = wake_bus_evt | (sleep_req_evt & (bus_active | pending));
    set_vec[B_DOVR]   = chg_vec[L_DOVR];
    set_vec[B_EWARN]  = chg_vec[L_ERR] | chg_vec[L_BUS];
    set_vec[B_TX]     = chg_vec[L_TX];
    set_vec[B_RX]     = rxfifo_nonempty;
  end

  assign rd_clr = reg_rd && (reg_addr == FLAG_ADDR);

  can_irq_flags #(.W(NFLAG), .LVL_BIT(B_RX)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (set_vec),
    .en         (en_q),
    .rd_clr     (rd_clr),
    .rx_release (rx_release),
    .flags      (flag_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)                                en_q <= '0;
    else if (reg_wr && reg_addr == EN_ADDR) en_q <= reg_wdata[NFLAG-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == FLAG_ADDR)    reg_rdata[NFLAG-1:0] = flag_vec;
    else if (reg_addr == EN_ADDR) reg_rdata[NFLAG-1:0] = en_q;
  end

  assign irq_n = ~pending;
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk
  import can_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  en,
  input logic              bus_err_evt,
  input logic              dovr_sts,
  input logic              rx_release,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              irq_n
);
  AST_GATED_BUSERR: assert property (@(posedge clk) disable iff (rst)
    (!en[B_BUSERR] && !flags[B_BUSERR]) |=> !flags[B_BUSERR]);  // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == FLAG_ADDR && !bus_err_evt) |=> !flags[B_BUSERR]);  // R3

  AST_RELEASE_MASK: assert property (@(posedge clk) disable iff (rst)
    rx_release |=> !flags[B_RX]);  // R5

  AST_DOVR_RISE: assert property (@(posedge clk) disable iff (rst)
    (en[B_DOVR] && dovr_sts && !$past(dovr_sts)) |=> flags[B_DOVR]);  // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == FLAG_ADDR && bus_err_evt && en[B_BUSERR]) |=> flags[B_BUSERR]);  // R11

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(|flags) |-> $rose(irq_n));  // R10
endmodule

bind can_irq_unit can_irq_unit_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .flags       (flag_vec),
  .en          (en_q),
  .bus_err_evt (bus_err_evt),
  .dovr_sts    (dovr_sts),
  .rx_release  (rx_release),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .irq_n       (irq_n)
);

// File: tb/can_irq_unit_tb_top.sv
`timescale 1ns/100ps
module can_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic bus_err_evt, arb_lost_evt, ep_cross_evt, wake_bus_evt, sleep_req_evt;
  logic bus_active, dovr_sts, err_sts, bus_sts, txbuf_sts, rxfifo_nonempty, rx_release;
  logic [4:0] reg_addr;
  logic reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_irq_unit dut_i (
    .clk(clk), .rst(rst),
    .bus_err_evt(bus_err_evt), .arb_lost_evt(arb_lost_evt), .ep_cross_evt(ep_cross_evt),
    .wake_bus_evt(wake_bus_evt), .sleep_req_evt(sleep_req_evt), .bus_active(bus_active),
    .dovr_sts(dovr_sts), .err_sts(err_sts), .bus_sts(bus_sts), .txbuf_sts(txbuf_sts),
    .rxfifo_nonempty(rxfifo_nonempty), .rx_release(rx_release),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  // which: 0 bus error, 1 arb lost, 2 err passive, 3 wake bus, 4 sleep req, 5 release
  task automatic pulse(input int which);
    case (which)
      0: bus_err_evt = 1'b1;
      1: arb_lost_evt = 1'b1;
      2: ep_cross_evt = 1'b1;
      3: wake_bus_evt = 1'b1;
      4: sleep_req_evt = 1'b1;
      default: rx_release = 1'b1;
    endcase
    step();
    bus_err_evt = 0; arb_lost_evt = 0; ep_cross_evt = 0;
    wake_bus_evt = 0; sleep_req_evt = 0; rx_release = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; step();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R12 irq_n after reset", {7'd0, irq_n}, 8'h01);
    rd_reg(5'd3, v); check("R12 flags after reset", v, 8'h00);
    rd_reg(5'd4, v); check("R12 enables after reset", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr_reg(5'd4, 8'hA5); rd_reg(5'd4, v); check("R2 enable readback", v, 8'hA5);
    wr_reg(5'd3, 8'hFF); rd_reg(5'd3, v); check("R1 flag write ignored", v, 8'h00);
    check("R1 irq_n after flag write", {7'd0, irq_n}, 8'h01);
    rd_reg(5'd5, v); check("R2 other address reads 0", v, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr_reg(5'd4, 8'h00);
    pulse(0); pulse(1);
    check("R2 disabled no irq", {7'd0, irq_n}, 8'h01);
    rd_reg(5'd3, v); check("R2 disabled no flag", v, 8'h00);
  endtask

  task automatic t_strobes();
    logic [7:0] v;
    wr_reg(5'd4, 8'hFF);
    pulse(0); pulse(1); pulse(2);
    check("R10 irq low while pending", {7'd0, irq_n}, 8'h00);
    rd_reg(5'd3, v); check("R8 strobe flags", v, 8'hE0);
    rd_reg(5'd3, v); check("R3 read cleared", v, 8'h00);
    check("R10 irq high after clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    dovr_sts = 1'b1; step();
    rd_reg(5'd3, v); check("R6 overrun rise", v, 8'h08);
    step(); step();
    rd_reg(5'd3, v); check("R6 overrun steady no set", v, 8'h00);
    dovr_sts = 1'b0; step();
    rd_reg(5'd3, v); check("R6 overrun fall no set", v, 8'h00);
    txbuf_sts = 1'b1; step();
    rd_reg(5'd3, v); check("R6 transmit rise", v, 8'h02);
    txbuf_sts = 1'b0; step();
    rd_reg(5'd3, v); check("R6 transmit fall no set", v, 8'h00);
  endtask

  task automatic t_ewarn();
    logic [7:0] v;
    err_sts = 1'b1; step();
    rd_reg(5'd3, v); check("R7 error status rise", v, 8'h04);
    err_sts = 1'b0; step();
    rd_reg(5'd3, v); check("R7 error status fall", v, 8'h04);
    bus_sts = 1'b1; step();
    rd_reg(5'd3, v); check("R7 bus status rise", v, 8'h04);
    bus_sts = 1'b0; step();
    rd_reg(5'd3, v); check("R7 bus status fall", v, 8'h04);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    rxfifo_nonempty = 1'b1; #1;
    check("R10 irq low on rx", {7'd0, irq_n}, 8'h00);
    rd_reg(5'd3, v); check("R4 receive flag", v, 8'h01);
    rd_reg(5'd3, v); check("R4 receive kept over read", v, 8'h01);
    pulse(5);
    rd_reg(5'd3, v); check("R5 masked after release", v, 8'h00);
    rd_reg(5'd3, v); check("R5 returns with more data", v, 8'h01);
    rxfifo_nonempty = 1'b0; pulse(5); step();
    rd_reg(5'd3, v); check("R5 stays clear when empty", v, 8'h00);
    rxfifo_nonempty = 1'b1; step();
    wr_reg(5'd4, 8'hFE);
    check("R10 irq high after rx enable off", {7'd0, irq_n}, 8'h01);
    rd_reg(5'd3, v); check("R4 enable gates receive", v, 8'h00);
    rxfifo_nonempty = 1'b0;
    wr_reg(5'd4, 8'hFF);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    bus_active = 1'b0; pulse(4);
    rd_reg(5'd3, v); check("R9 sleep idle no wake", v, 8'h00);
    bus_active = 1'b1; pulse(4); bus_active = 1'b0;
    rd_reg(5'd3, v); check("R9 sleep while bus active", v, 8'h10);
    rxfifo_nonempty = 1'b1; step(); pulse(4);
    rd_reg(5'd3, v); check("R9 sleep while pending", v, 8'h11);
    rxfifo_nonempty = 1'b0; step();
    pulse(3);
    rd_reg(5'd3, v); check("R9 bus wake strobe", v, 8'h10);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    bus_err_evt = 1'b1;
    rd_reg(5'd3, v);
    bus_err_evt = 1'b0;
    check("R11 read value before event", v, 8'h00);
    rd_reg(5'd3, v); check("R11 event kept over read", v, 8'h80);
  endtask

  task automatic t_reset2();
    logic [7:0] v;
    pulse(1);
    do_reset();
    check("R12 irq high after reset", {7'd0, irq_n}, 8'h01);
    rd_reg(5'd4, v); check("R12 enables cleared", v, 8'h00);
    rd_reg(5'd3, v); check("R12 flags cleared", v, 8'h00);
  endtask

  initial begin
    rst = 1; bus_err_evt = 0; arb_lost_evt = 0; ep_cross_evt = 0; wake_bus_evt = 0;
    sleep_req_evt = 0; bus_active = 0; dovr_sts = 0; err_sts = 0; bus_sts = 0;
    txbuf_sts = 0; rxfifo_nonempty = 0; rx_release = 0;
    reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    #1;
    do_reset();
    t_reset();
    t_regs();
    t_gate();
    t_strobes();
    t_edges();
    t_ewarn();
    t_rx();
    t_wake();
    t_collide();
    t_reset2();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule